// File: doc/BRIEF.md
# Cache Line Delete Manager

This block runs beside a set-associative cache data array whose words carry single-error-correct, double-error-detect codes. The array's read path reports an ECC outcome for each read, tagged with the set and way it came from. For every correctable outcome the manager asks for the corrected data to be written back into the array, and it adds the event to a global correctable-error count. When that count reaches a threshold, it raises a processor deallocation request.

Lines that keep failing are retired. A line is deleted on its second correctable error, or at once on an uncorrectable error. Its set and way go into a small delete table. Deleted ways are removed from the lookup hit vector and from the victim mask that the replacement logic uses. A deleted line that is dirty and was hit by a correctable error is also cast out to the next level. The table holds six entries and that is the whole budget. When the sixth deletion happens, a persistent deconfigure flag is raised for the next boot. After that, faulty lines are only reported as errors.

Every strobe output is registered. It describes the ECC event presented on the cycle before it appears.

Top module: `cld_top`

## Requirements
- R1: After reset, all strobe outputs, `delCount`, `deconfig` and `deallocReq` are 0, and `vicMask` is all ones for every set.
- R2: An ECC event with `eccKind` = 2'b01 (correctable) on a line that is not deleted pulses `fixWrite` for one cycle, on the cycle after the event. The first such event on a line deletes nothing.
- R3: A second correctable event on the same set and way deletes the line. `lineInval` pulses and `delCount` goes up by one. If `eccDirty` was 1, `castOut` pulses in the same cycle.
- R4: An event with `eccKind` = 2'b10 (uncorrectable) on a line that is not deleted deletes it at once. `lineInval` pulses, `castOut` stays 0 even if the line is dirty, and `fixWrite` stays 0.
- R5: While `lkValid` is 1, `lkHit` equals `lkTagHit` with the deleted ways of `lkSet` cleared, and `lkMiss` is 1 when `lkHit` is zero. The ways that are not deleted are unaffected.
- R6: Bit w of `vicMask` is 0 exactly when way w of `vicSet` is deleted.
- R7: `delCount` never exceeds 6. The deletion that brings it to 6 sets `deconfig`, and `deconfig` stays set until reset.
- R8: When a deletion would occur but 6 lines are already deleted, `overBudgetErr` pulses instead. No `lineInval` pulse follows, and the lookup and victim masks do not change.
- R9: Each correctable event on a line that is not deleted adds one to an internal count. When the count reaches `CE_THRESH` (default 8), `deallocReq` is set, and it stays set until reset.
- R10: An ECC event on a line that is already deleted has no effect. No strobe pulses, and the event adds nothing to the correctable count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup strobe |
| lkSet | input | SET_W | Set being looked up |
| lkTagHit | input | WAYS | Raw tag-compare hit vector |
| lkHit | output | WAYS | Hit vector with deleted ways removed |
| lkMiss | output | 1 | Lookup with no surviving hit |
| eccValid | input | 1 | ECC outcome present |
| eccKind | input | 2 | 01 correctable, 10 uncorrectable, other values no event |
| eccSet | input | SET_W | Set of the reported read |
| eccWay | input | WAY_W | Way of the reported read |
| eccDirty | input | 1 | Reported line holds dirty data |
| vicSet | input | SET_W | Set the replacement logic is allocating in |
| vicMask | output | WAYS | Ways allowed as victims |
| fixWrite | output | 1 | Write corrected data back to the array |
| lineInval | output | 1 | Invalidate the reported line (deleted) |
| castOut | output | 1 | Write corrected dirty line to next level |
| overBudgetErr | output | 1 | Deletion refused, budget exhausted |
| delCount | output | DEL_W | Number of deleted lines |
| deconfig | output | 1 | Persistent deconfigure flag |
| deallocReq | output | 1 | Processor deallocation request |

## Verification
On every cycle, the assertions check the following:
- The deletion count stays within its bound.
- The deconfigure flag and the deallocation request are sticky, and the deconfigure flag implies a full table.
- A cast-out comes only with an invalidate, and never after an uncorrectable event.
- A refused deletion never invalidates.
- The filtered hit vector is a subset of the raw one.

Only the bench's scenarios can show the rest:
- the strike-then-delete history of individual lines,
- the exact set and way that the masks exclude,
- events on already deleted lines being ignored,
- the count at which deallocation is requested.

// File: rtl/cld_pkg.sv
package cld_pkg;
  typedef enum logic [1:0] {
    EVT_NONE = 2'b00,
    EVT_CE   = 2'b01,
    EVT_UE   = 2'b10,
    EVT_RSVD = 2'b11
  } eccKind_t;

  typedef struct packed {
    logic ceInc;
    logic setStrike;
    logic doDelete;
  } cldStrobe_t;
endpackage

// File: rtl/cld_ctrl.sv
module cld_ctrl
  import cld_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evValid,
  input  logic [1:0] evKind,
  input  logic       evDirty,
  input  logic       evStruck,
  input  logic       evDeleted,
  input  logic       budgetLeft,
  output cldStrobe_t strobe,
  output logic       fixWrite,
  output logic       lineInval,
  output logic       castOut,
  output logic       overBudgetErr
);
  logic isCe, isUe, wantDel, refuse;

  always_comb begin
    isCe    = evValid && (evKind == EVT_CE) && !evDeleted;
    isUe    = evValid && (evKind == EVT_UE) && !evDeleted;
    wantDel = isUe || (isCe && evStruck);
    refuse  = wantDel && !budgetLeft;
    strobe.ceInc     = isCe;
    strobe.setStrike = isCe && !evStruck;
    strobe.doDelete  = wantDel && budgetLeft;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fixWrite      <= 1'b0;
      lineInval     <= 1'b0;
      castOut       <= 1'b0;
      overBudgetErr <= 1'b0;
    end else begin
      fixWrite      <= isCe;
      lineInval     <= strobe.doDelete;
      castOut       <= strobe.doDelete && isCe && evDirty;
      overBudgetErr <= refuse;
    end
  end

  AST_CAST_NEEDS_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    castOut |-> lineInval); // R3
  AST_UE_NO_CAST: assert property (@(posedge clk) disable iff (!rst_n)
    (evValid && evKind == EVT_UE) |=> !castOut && !fixWrite); // R4
  AST_OVER_NO_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    overBudgetErr |-> !lineInval); // R8
endmodule

// File: rtl/cld_dp.sv
module cld_dp
  import cld_pkg::*;
#(
  parameter int SETS      = 16,
  parameter int WAYS      = 4,
  parameter int DEL_MAX   = 6,
  parameter int CE_THRESH = 8,
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int DEL_W  = $clog2(DEL_MAX + 1),
  localparam int CE_W   = $clog2(CE_THRESH + 1),
  localparam int LINES  = SETS * WAYS,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cldStrobe_t       strobe,
  input  logic [SET_W-1:0] evSet,
  input  logic [WAY_W-1:0] evWay,
  input  logic [SET_W-1:0] lkSet,
  input  logic [SET_W-1:0] vicSet,
  output logic [WAYS-1:0]  lkDelMask,
  output logic [WAYS-1:0]  vicDelMask,
  output logic             evStruck,
  output logic             evDeleted,
  output logic             budgetLeft,
  output logic [DEL_W-1:0] delCount,
  output logic             deconfig,
  output logic             deallocReq
);
  logic [LINES-1:0] strike;
  logic [DEL_MAX-1:0] entValid;
  logic [SET_W-1:0] entSet [DEL_MAX];
  logic [WAY_W-1:0] entWay [DEL_MAX];
  logic [CE_W-1:0] ceCnt;
  logic [LINE_W-1:0] lineIdx;

  assign lineIdx    = LINE_W'(evSet) * LINE_W'(WAYS) + LINE_W'(evWay);
  assign evStruck   = strike[lineIdx];
  assign budgetLeft = (delCount < DEL_W'(DEL_MAX));

  for (genvar e = 0; e < DEL_MAX; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entValid[e] <= 1'b0;
        entSet[e]   <= '0;
        entWay[e]   <= '0;
      end else if (strobe.doDelete && delCount == DEL_W'(e)) begin
        entValid[e] <= 1'b1;
        entSet[e]   <= evSet;
        entWay[e]   <= evWay;
      end
    end
  end

  always_comb begin
    lkDelMask  = '0;
    vicDelMask = '0;
    evDeleted  = 1'b0;
    for (int e = 0; e < DEL_MAX; e++) begin
      if (entValid[e]) begin
        if (entSet[e] == lkSet)  lkDelMask[entWay[e]]  = 1'b1;
        if (entSet[e] == vicSet) vicDelMask[entWay[e]] = 1'b1;
        if (entSet[e] == evSet && entWay[e] == evWay) evDeleted = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strike     <= '0;
      delCount   <= '0;
      deconfig   <= 1'b0;
      ceCnt      <= '0;
      deallocReq <= 1'b0;
    end else begin
      if (strobe.setStrike) strike[lineIdx] <= 1'b1;
      if (strobe.doDelete) begin
        delCount <= delCount + 1'b1;
        if (delCount == DEL_W'(DEL_MAX - 1)) deconfig <= 1'b1;
      end
      if (strobe.ceInc) begin
        if (ceCnt != CE_W'(CE_THRESH)) ceCnt <= ceCnt + 1'b1;
        if (ceCnt >= CE_W'(CE_THRESH - 1)) deallocReq <= 1'b1;
      end
    end
  end

  AST_DEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    delCount <= DEL_W'(DEL_MAX)); // R7
  AST_DECONFIG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    deconfig |-> delCount == DEL_W'(DEL_MAX)); // R7
  AST_DECONFIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    deconfig |=> deconfig); // R7
  AST_DEALLOC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    deallocReq |=> deallocReq); // R9
  AST_DELETE_IN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doDelete |-> budgetLeft && !evDeleted); // R8
endmodule

// File: rtl/cld_top.sv
module cld_top
  import cld_pkg::*;
#(
  parameter int SETS      = 16,
  parameter int WAYS      = 4,
  parameter int DEL_MAX   = 6,
  parameter int CE_THRESH = 8,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int DEL_W = $clog2(DEL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lkValid,
  input  logic [SET_W-1:0] lkSet,
  input  logic [WAYS-1:0]  lkTagHit,
  output logic [WAYS-1:0]  lkHit,
  output logic             lkMiss,
  input  logic             eccValid,
  input  logic [1:0]       eccKind,
  input  logic [SET_W-1:0] eccSet,
  input  logic [WAY_W-1:0] eccWay,
  input  logic             eccDirty,
  input  logic [SET_W-1:0] vicSet,
  output logic [WAYS-1:0]  vicMask,
  output logic             fixWrite,
  output logic             lineInval,
  output logic             castOut,
  output logic             overBudgetErr,
  output logic [DEL_W-1:0] delCount,
  output logic             deconfig,
  output logic             deallocReq
);
  cldStrobe_t strobe;
  logic [WAYS-1:0] lkDelMask, vicDelMask;
  logic evStruck, evDeleted, budgetLeft;

  cld_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .evValid(eccValid), .evKind(eccKind),
    .evDirty(eccDirty), .evStruck(evStruck), .evDeleted(evDeleted),
    .budgetLeft(budgetLeft), .strobe(strobe), .fixWrite(fixWrite),
    .lineInval(lineInval), .castOut(castOut), .overBudgetErr(overBudgetErr)
  );

  cld_dp #(.SETS(SETS), .WAYS(WAYS), .DEL_MAX(DEL_MAX), .CE_THRESH(CE_THRESH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .evSet(eccSet), .evWay(eccWay),
    .lkSet(lkSet), .vicSet(vicSet), .lkDelMask(lkDelMask), .vicDelMask(vicDelMask),
    .evStruck(evStruck), .evDeleted(evDeleted), .budgetLeft(budgetLeft),
    .delCount(delCount), .deconfig(deconfig), .deallocReq(deallocReq)
  );

  assign lkHit   = lkValid ? (lkTagHit & ~lkDelMask) : '0;
  assign lkMiss  = lkValid && (lkHit == '0);
  assign vicMask = ~vicDelMask;

  AST_HIT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (lkHit & ~lkTagHit) == '0); // R5
endmodule

// File: tb/cld_top_tb_top.sv
module cld_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       lkValid = 1'b0;
  logic [3:0] lkSet = '0;
  logic [3:0] lkTagHit = '0;
  logic [3:0] lkHit;
  logic       lkMiss;
  logic       eccValid = 1'b0;
  logic [1:0] eccKind = 2'b00;
  logic [3:0] eccSet = '0;
  logic [1:0] eccWay = '0;
  logic       eccDirty = 1'b0;
  logic [3:0] vicSet = '0;
  logic [3:0] vicMask;
  logic fixWrite, lineInval, castOut, overBudgetErr, deconfig, deallocReq;
  logic [2:0] delCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cld_top dut_i (
    .clk(clk), .rst_n(rst_n), .lkValid(lkValid), .lkSet(lkSet), .lkTagHit(lkTagHit),
    .lkHit(lkHit), .lkMiss(lkMiss), .eccValid(eccValid), .eccKind(eccKind),
    .eccSet(eccSet), .eccWay(eccWay), .eccDirty(eccDirty), .vicSet(vicSet),
    .vicMask(vicMask), .fixWrite(fixWrite), .lineInval(lineInval), .castOut(castOut),
    .overBudgetErr(overBudgetErr), .delCount(delCount), .deconfig(deconfig),
    .deallocReq(deallocReq)
  );

  typedef struct packed {
    logic [1:0] kind;
    logic [3:0] set;
    logic [1:0] way;
    logic       dirty;
    logic       fix;
    logic       inv;
    logic       cast;
    logic       ov;
    logic [2:0] del;
    logic       dcf;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{2'b01, 4'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0}, // R2 first strike
    '{2'b01, 4'd1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0}, // R3 delete, dirty
    '{2'b01, 4'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0}, // R10 ignored
    '{2'b10, 4'd2, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0}, // R4 UE dirty
    '{2'b01, 4'd3, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0}, // R2
    '{2'b01, 4'd3, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd3, 1'b0}, // R3 clean
    '{2'b10, 4'd4, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0}, // R4
    '{2'b10, 4'd5, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd5, 1'b0}, // R4
    '{2'b10, 4'd6, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd6, 1'b1}, // R7 sixth
    '{2'b10, 4'd7, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd6, 1'b1}, // R8 over budget
    '{2'b01, 4'd8, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd6, 1'b1}, // R2
    '{2'b01, 4'd8, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd6, 1'b1}  // R8 CE over budget
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ecc_evt(input logic [1:0] k, input logic [3:0] s, input logic [1:0] w,
                         input logic d);
    eccValid = 1'b1; eccKind = k; eccSet = s; eccWay = w; eccDirty = d;
    @(posedge clk);
    @(negedge clk);
    eccValid = 1'b0; eccKind = 2'b00; eccDirty = 1'b0;
  endtask

  task automatic look(input logic [3:0] s, input logic [3:0] th, input logic [3:0] expHit,
                      input string req);
    lkValid = 1'b1; lkSet = s; lkTagHit = th;
    #1;
    chk(req, {28'd0, lkHit}, {28'd0, expHit});
    chk(req, {31'd0, lkMiss}, {31'd0, (expHit == 4'd0)});
    lkValid = 1'b0;
  endtask

  task automatic vic(input logic [3:0] s, input logic [3:0] expMask, input string req);
    vicSet = s;
    #1;
    chk(req, {28'd0, vicMask}, {28'd0, expMask});
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", {28'd0, fixWrite, lineInval, castOut, overBudgetErr}, 32'd0);
    chk("R1", {29'd0, delCount}, 32'd0);
    chk("R1", {30'd0, deconfig, deallocReq}, 32'd0);
    for (int s = 0; s < 16; s++) vic(4'(s), 4'b1111, "R1");

    for (int i = 0; i < NVEC; i++) begin
      ecc_evt(VEC[i].kind, VEC[i].set, VEC[i].way, VEC[i].dirty);
      chk("R2 fixWrite", {31'd0, fixWrite}, {31'd0, VEC[i].fix});
      chk("R3/R4 lineInval", {31'd0, lineInval}, {31'd0, VEC[i].inv});
      chk("R3/R4 castOut", {31'd0, castOut}, {31'd0, VEC[i].cast});
      chk("R8 overBudgetErr", {31'd0, overBudgetErr}, {31'd0, VEC[i].ov});
      chk("R7 delCount", {29'd0, delCount}, {29'd0, VEC[i].del});
      chk("R7 deconfig", {31'd0, deconfig}, {31'd0, VEC[i].dcf});
    end

    // R5 lookups against deleted lines
    look(4'd1, 4'b1111, 4'b1110, "R5");
    look(4'd1, 4'b0001, 4'b0000, "R5");
    look(4'd3, 4'b0010, 4'b0010, "R5");
    look(4'd6, 4'b0010, 4'b0000, "R5");
    look(4'd7, 4'b0100, 4'b0100, "R8 lookup unchanged");
    look(4'd8, 4'b0001, 4'b0001, "R8 lookup unchanged");
    // R6 victim masks
    vic(4'd1, 4'b1110, "R6");
    vic(4'd2, 4'b1101, "R6");
    vic(4'd4, 4'b0111, "R6");
    vic(4'd9, 4'b1111, "R6");
    vic(4'd7, 4'b1111, "R8 victim unchanged");

    // R9 six counted CEs so far; seventh keeps request low, eighth raises it
    chk("R9", {31'd0, deallocReq}, 32'd0);
    ecc_evt(2'b01, 4'd9, 2'd0, 1'b0);
    chk("R9", {31'd0, deallocReq}, 32'd0);
    ecc_evt(2'b01, 4'd10, 2'd0, 1'b0);
    chk("R9", {31'd0, deallocReq}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R9 sticky", {31'd0, deallocReq}, 32'd1);
    chk("R7 sticky", {31'd0, deconfig}, 32'd1);
    // R2 reserved kind is no event
    ecc_evt(2'b11, 4'd11, 2'd0, 1'b1);
    chk("R2 reserved", {28'd0, fixWrite, lineInval, castOut, overBudgetErr}, 32'd0);

    finish_up();
  end
endmodule